// File: doc/BRIEF.md
# Periodic Traffic Activity Monitor

The block watches one traffic source and turns its event pulses into a per-period activity figure. Each event pulse adds a programmable weight to an accumulator. A millisecond tick drives a period counter, and every period closes one sample. The sample is compared with an upper and a lower raw watermark. A breach has to last for a programmable number of back-to-back periods before it is flagged. The block also keeps an exponential moving average of the samples, and that average has its own pair of watermarks.

Software drives the block through a flat register file with a write port and a read port. It programs the thresholds and the averaging constant, seeds the average, reads the average back, and acknowledges status bits by writing ones to them. A single interrupt line reports any status bit whose condition is enabled. A power manager that wants to raise a clock under sustained load, or lower it when the source goes quiet, would consume that line.

Top module: `act_monitor`

## Requirements
- R1: After synchronous reset every register reads zero and `irq` is low.
- R2: Word addresses are: 0 control, 1 period (low 16 bits), 2 raw upper mark, 3 raw lower mark, 4 average upper mark, 5 average lower mark, 6 seed, 7 weight, 8 average (read only), 9 status. Read data appears on the cycle after the address is presented. Control fields are: run at bit 31, upper-streak enable at bit 30, lower-streak enable at bit 29, upper-streak length minus one at bits 28:26, lower-streak length minus one at bits 25:23, average-above enable at bit 21, average-below enable at bit 20, periodic enable at bit 18, and K at bits 12:10. All other control bits read as zero.
- R3: While bits 31 and 18 are both set, each event pulse adds the weight to the accumulator. A sample closes on the tick that completes period+1 ticks. An event on that same cycle belongs to the closing sample, and the accumulator then restarts from zero.
- R4: A 0-to-1 write of bit 31 loads the average from the seed. One cycle after a sample closes, the average becomes avg + floor((sample − avg) / 2^(K+1)).
- R5: A sample strictly above the raw upper mark extends the upper streak. The streak sets status bit 31 when it reaches the programmed length, and then restarts from zero. A sample that is not above the mark resets the streak.
- R6: A sample strictly below the raw lower mark drives the lower streak in the same way, with bits 25:23 as the length, and sets status bit 30.
- R7: After an update, an average strictly above the average upper mark sets status bit 29 when bit 21 is set. An average strictly below the average lower mark sets status bit 28 when bit 20 is set.
- R8: Writing to the status word clears each status bit written as one and leaves bits written as zero. A status bit set in the same cycle survives the clear.
- R9: `irq` is the registered OR of the status bits whose enables are set: bit 31 with bit 30, bit 30 with bit 29, bit 29 with bit 21, bit 28 with bit 20. It follows the status and control registers one cycle later.
- R10: While bit 31 or bit 18 is clear, events and ticks are ignored, the average holds, and the register contents are kept.
- R11: The accumulator saturates at all ones instead of wrapping.
- R12: While a streak enable is clear, its streak stays at zero and its status bit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Registered read data |
| ms_tick | input | 1 | One-cycle millisecond tick |
| evt_pulse | input | 1 | One-cycle traffic event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
Some properties are checked on every cycle. The accumulator never decreases except when a sample closes or the monitor restarts. Each new average lies between the old average and the sample. The average holds when no sample closes. A disabled streak stays at zero, and a miss clears a streak. Written-one status bits are gone on the next cycle unless they were set again, and `irq` stays low while the status is empty. Other behaviour only shows up in scenarios. These include exact period length, the event that lands on the closing tick, the floor rounding of negative steps, streaks broken by a miss, saturation under a huge weight, reseeding on re-enable, and enable masking of a status bit that is already latched. The bench drives those scenarios against a behavioural model on every clock.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int NW = 3;  // streak length field width
  localparam int KW = 3;  // averaging constant width

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_PER  = 4'd1;
  localparam logic [3:0] A_UPW  = 4'd2;
  localparam logic [3:0] A_LOW  = 4'd3;
  localparam logic [3:0] A_AUPW = 4'd4;
  localparam logic [3:0] A_ALOW = 4'd5;
  localparam logic [3:0] A_SEED = 4'd6;
  localparam logic [3:0] A_WGT  = 4'd7;
  localparam logic [3:0] A_AVG  = 4'd8;
  localparam logic [3:0] A_STAT = 4'd9;

  // internal status vector index (readback bits 28..31)
  localparam int ST_AL = 0;
  localparam int ST_AH = 1;
  localparam int ST_CB = 2;
  localparam int ST_CA = 3;

  typedef struct packed {
    logic          run;
    logic          up_en;
    logic          dn_en;
    logic [NW-1:0] up_len;
    logic [NW-1:0] dn_len;
    logic          avg_hi_en;
    logic          avg_lo_en;
    logic          periodic;
    logic [KW-1:0] k;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.run       = w[31];
    c.up_en     = w[30];
    c.dn_en     = w[29];
    c.up_len    = w[28:26];
    c.dn_len    = w[25:23];
    c.avg_hi_en = w[21];
    c.avg_lo_en = w[20];
    c.periodic  = w[18];
    c.k         = w[12:10];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[31]    = c.run;
    w[30]    = c.up_en;
    w[29]    = c.dn_en;
    w[28:26] = c.up_len;
    w[25:23] = c.dn_len;
    w[21]    = c.avg_hi_en;
    w[20]    = c.avg_lo_en;
    w[18]    = c.periodic;
    w[12:10] = c.k;
    return w;
  endfunction
endpackage

// File: rtl/amon_regs.sv
module amon_regs
  import amon_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] avg_i,
  input  logic [3:0]    set_i,
  output ctrl_t         ctrl_o,
  output logic [PW-1:0] period_o,
  output logic [DW-1:0] up_wm_o,
  output logic [DW-1:0] lo_wm_o,
  output logic [DW-1:0] avg_up_wm_o,
  output logic [DW-1:0] avg_lo_wm_o,
  output logic [DW-1:0] seed_o,
  output logic [DW-1:0] weight_o,
  output logic          start_o,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [PW-1:0] period_q;
  logic [DW-1:0] upw_q, low_q, aupw_q, alow_q, seed_q, wgt_q;
  logic [3:0]    st_q;
  logic [3:0]    st_mask;
  logic [3:0]    st_clr;
  logic [DW-1:0] rd_q;
  logic          irq_q;

  assign start_o = wr_en && (wr_addr == AW'(A_CTRL)) && wr_data[31] && !ctrl_q.run;
  assign st_clr  = (wr_en && (wr_addr == AW'(A_STAT))) ? wr_data[DW-1:DW-4] : 4'b0;

  always_comb begin
    st_mask        = '0;
    st_mask[ST_CA] = ctrl_q.up_en;
    st_mask[ST_CB] = ctrl_q.dn_en;
    st_mask[ST_AH] = ctrl_q.avg_hi_en;
    st_mask[ST_AL] = ctrl_q.avg_lo_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      upw_q    <= '0;
      low_q    <= '0;
      aupw_q   <= '0;
      alow_q   <= '0;
      seed_q   <= '0;
      wgt_q    <= '0;
      st_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          AW'(A_CTRL): ctrl_q   <= ctrl_unpack(wr_data[31:0]);
          AW'(A_PER):  period_q <= wr_data[PW-1:0];
          AW'(A_UPW):  upw_q    <= wr_data;
          AW'(A_LOW):  low_q    <= wr_data;
          AW'(A_AUPW): aupw_q   <= wr_data;
          AW'(A_ALOW): alow_q   <= wr_data;
          AW'(A_SEED): seed_q   <= wr_data;
          AW'(A_WGT):  wgt_q    <= wr_data;
          default: ;
        endcase
      end
      st_q  <= (st_q & ~st_clr) | set_i;
      irq_q <= |(st_q & st_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        AW'(A_CTRL): rd_q <= DW'(ctrl_pack(ctrl_q));
        AW'(A_PER):  rd_q <= DW'(period_q);
        AW'(A_UPW):  rd_q <= upw_q;
        AW'(A_LOW):  rd_q <= low_q;
        AW'(A_AUPW): rd_q <= aupw_q;
        AW'(A_ALOW): rd_q <= alow_q;
        AW'(A_SEED): rd_q <= seed_q;
        AW'(A_WGT):  rd_q <= wgt_q;
        AW'(A_AVG):  rd_q <= avg_i;
        AW'(A_STAT): rd_q <= {st_q, (DW-4)'(0)};
        default:     rd_q <= '0;
      endcase
    end
  end

  assign rd_data     = rd_q;
  assign irq_o       = irq_q;
  assign ctrl_o      = ctrl_q;
  assign period_o    = period_q;
  assign up_wm_o     = upw_q;
  assign lo_wm_o     = low_q;
  assign avg_up_wm_o = aupw_q;
  assign avg_lo_wm_o = alow_q;
  assign seed_o      = seed_q;
  assign weight_o    = wgt_q;

  // R8: a written-one status bit is gone next cycle unless set again
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(A_STAT)) |=> ((st_q & $past(wr_data[DW-1:DW-4] & ~set_i)) == 4'b0));

  // R9: no pending status means no interrupt on the next cycle
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    (st_q == 4'b0) |=> !irq_o);
endmodule

// File: rtl/amon_sampler.sv
module amon_sampler #(
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          evt_i,
  input  logic [DW-1:0] weight_i,
  input  logic [PW-1:0] period_i,
  output logic          close_o,
  output logic [DW-1:0] sample_o
);
  logic [DW-1:0] acc_q;
  logic [PW-1:0] ms_q;
  logic          close_q;
  logic [DW-1:0] sample_q;
  logic [DW:0]   sum;
  logic [DW-1:0] acc_sat;
  logic          last;

  assign sum     = {1'b0, acc_q} + {1'b0, (evt_i ? weight_i : '0)};
  assign acc_sat = sum[DW] ? '1 : sum[DW-1:0];
  assign last    = tick_i && (ms_q == period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      ms_q     <= '0;
      close_q  <= 1'b0;
      sample_q <= '0;
    end else if (start_i) begin
      acc_q   <= '0;
      ms_q    <= '0;
      close_q <= 1'b0;
    end else if (run_i) begin
      if (last) begin
        close_q  <= 1'b1;
        sample_q <= acc_sat;
        acc_q    <= '0;
        ms_q     <= '0;
      end else begin
        close_q <= 1'b0;
        acc_q   <= acc_sat;
        if (tick_i) ms_q <= ms_q + PW'(1);
      end
    end else begin
      close_q <= 1'b0;
    end
  end

  assign close_o  = close_q;
  assign sample_o = sample_q;

  // R11: between closes the accumulator never goes down (no wrap)
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !last) |=> (acc_q >= $past(acc_q)));

  // R3: a closing tick restarts the accumulator and flags the sample
  a_r3_close_restart: assert property (@(posedge clk) disable iff (rst)
    (run_i && !start_i && last) |=> (acc_q == '0 && close_o));
endmodule

// File: rtl/amon_avg.sv
module amon_avg #(
  parameter int DW = 32,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          close_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] seed_i,
  input  logic [KW-1:0] k_i,
  input  logic [DW-1:0] hi_wm_i,
  input  logic [DW-1:0] lo_wm_i,
  input  logic          hi_en_i,
  input  logic          lo_en_i,
  output logic [DW-1:0] avg_o,
  output logic          hi_set_o,
  output logic          lo_set_o
);
  logic [DW-1:0]        avg_q;
  logic signed [DW:0]   diff;
  logic signed [DW:0]   step;
  logic [KW:0]          sh;
  logic [DW-1:0]        avg_new;

  assign sh   = {1'b0, k_i} + (KW+1)'(1);
  assign diff = $signed({1'b0, sample_i}) - $signed({1'b0, avg_q});
  assign step = diff >>> sh;
  assign avg_new = step[DW] ? (avg_q - (~step[DW-1:0] + DW'(1)))
                            : (avg_q + step[DW-1:0]);

  always_ff @(posedge clk) begin
    if (rst)          avg_q <= '0;
    else if (start_i) avg_q <= seed_i;
    else if (close_i) avg_q <= avg_new;
  end

  assign hi_set_o = close_i && !start_i && hi_en_i && (avg_new > hi_wm_i);
  assign lo_set_o = close_i && !start_i && lo_en_i && (avg_new < lo_wm_i);
  assign avg_o    = avg_q;

  // R4: the new average lies between the old average and the sample
  a_r4_between: assert property (@(posedge clk) disable iff (rst)
    (close_i && !start_i) |=>
      (($past(sample_i) >= $past(avg_q)) ?
         (avg_q >= $past(avg_q) && avg_q <= $past(sample_i)) :
         (avg_q <= $past(avg_q) && avg_q >= $past(sample_i))));

  // R10: without a closed sample or a restart the average holds
  a_r10_avg_hold: assert property (@(posedge clk) disable iff (rst)
    (!close_i && !start_i) |=> $stable(avg_q));
endmodule

// File: rtl/amon_streak.sv
module amon_streak #(
  parameter int DW    = 32,
  parameter int NW    = 3,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          en_i,
  input  logic          close_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] wm_i,
  input  logic [NW-1:0] len_i,
  output logic          fire_o
);
  logic [NW-1:0] cnt_q;
  logic          hit;

  generate
    if (ABOVE) begin : g_above
      assign hit = sample_i > wm_i;
    end else begin : g_below
      assign hit = sample_i < wm_i;
    end
  endgenerate

  assign fire_o = close_i && en_i && !start_i && hit && (cnt_q == len_i);

  always_ff @(posedge clk) begin
    if (rst || start_i || !en_i) begin
      cnt_q <= '0;
    end else if (close_i) begin
      if (!hit || fire_o) cnt_q <= '0;
      else                cnt_q <= cnt_q + NW'(1);
    end
  end

  // R12: a disabled direction keeps its streak at zero
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));

  // R5: a sample that misses the mark breaks the streak
  a_r5_miss_breaks: assert property (@(posedge clk) disable iff (rst)
    (close_i && en_i && !hit) |=> (cnt_q == '0));
endmodule

// File: rtl/act_monitor.sv
module act_monitor
  import amon_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ms_tick,
  input  logic          evt_pulse,
  output logic          irq
);
  localparam int NDIR = 2;

  ctrl_t         ctrl;
  logic [PW-1:0] period;
  logic [DW-1:0] up_wm, lo_wm, aup_wm, alo_wm, seed, weight, avg;
  logic          start, close;
  logic [DW-1:0] sample;
  logic [3:0]    set_bits;
  logic          ah_set, al_set;
  logic [NDIR-1:0] fire;
  logic [NDIR-1:0] dir_en;
  logic [NW-1:0]   dir_len [NDIR];
  logic [DW-1:0]   dir_wm  [NDIR];

  amon_regs #(.DW(DW), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .avg_i(avg), .set_i(set_bits),
    .ctrl_o(ctrl), .period_o(period), .up_wm_o(up_wm), .lo_wm_o(lo_wm),
    .avg_up_wm_o(aup_wm), .avg_lo_wm_o(alo_wm), .seed_o(seed),
    .weight_o(weight), .start_o(start), .irq_o(irq)
  );

  amon_sampler #(.DW(DW), .PW(PW)) u_samp (
    .clk(clk), .rst(rst), .start_i(start), .run_i(ctrl.run && ctrl.periodic),
    .tick_i(ms_tick), .evt_i(evt_pulse), .weight_i(weight), .period_i(period),
    .close_o(close), .sample_o(sample)
  );

  amon_avg #(.DW(DW), .KW(KW)) u_avg (
    .clk(clk), .rst(rst), .start_i(start), .close_i(close), .sample_i(sample),
    .seed_i(seed), .k_i(ctrl.k), .hi_wm_i(aup_wm), .lo_wm_i(alo_wm),
    .hi_en_i(ctrl.avg_hi_en), .lo_en_i(ctrl.avg_lo_en), .avg_o(avg),
    .hi_set_o(ah_set), .lo_set_o(al_set)
  );

  // direction 0 watches the upper mark, direction 1 the lower one
  assign dir_en[0]  = ctrl.up_en;
  assign dir_en[1]  = ctrl.dn_en;
  assign dir_len[0] = ctrl.up_len;
  assign dir_len[1] = ctrl.dn_len;
  assign dir_wm[0]  = up_wm;
  assign dir_wm[1]  = lo_wm;

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      amon_streak #(.DW(DW), .NW(NW), .ABOVE(d == 0)) u_streak (
        .clk(clk), .rst(rst), .start_i(start), .en_i(dir_en[d]),
        .close_i(close), .sample_i(sample), .wm_i(dir_wm[d]),
        .len_i(dir_len[d]), .fire_o(fire[d])
      );
    end
  endgenerate

  always_comb begin
    set_bits        = '0;
    set_bits[ST_CA] = fire[0];
    set_bits[ST_CB] = fire[1];
    set_bits[ST_AH] = ah_set;
    set_bits[ST_AL] = al_set;
  end
endmodule

// File: tb/sim_act_monitor.sv
`timescale 1ns/1ps
module sim_act_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ms_tick = 1'b0;
  logic        evt_pulse = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  act_monitor u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ms_tick(ms_tick),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] a);
    if (a == 4'd8) return "R4 avg readback";
    if (a == 4'd9) return "R8 status readback";
    return "R2 register readback";
  endfunction

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] CTRL_MASK = 32'hFFB4_1C00;
  logic [31:0] m_r [10];
  logic [31:0] m_acc, m_sq, m_rd;
  logic [15:0] m_ms;
  int          m_ca, m_cb;
  logic        m_cq, m_irq, started = 1'b0;
  logic [3:0]  m_ra;

  always @(posedge clk) begin : model
    logic [31:0] ctl, inc, nav, n_avg, n_acc, n_sq;
    logic [32:0] sum;
    logic [3:0]  st, setb, mask;
    logic [15:0] n_ms;
    logic        start, run, last, n_cq, hit;
    longint      d;
    int          n_ca, n_cb;
    if (rst) begin
      foreach (m_r[i]) m_r[i] = '0;
      m_acc = '0; m_sq = '0; m_rd = '0; m_ms = '0;
      m_ca = 0; m_cb = 0; m_cq = 1'b0; m_irq = 1'b0; m_ra = '0;
      started = 1'b1;
    end else begin
      ctl  = m_r[0];
      mask = {ctl[30], ctl[29], ctl[21], ctl[20]};
      m_ra = rd_addr;
      m_rd = (rd_addr <= 4'd9) ? m_r[rd_addr] : 32'h0;
      m_irq = |(m_r[9][31:28] & mask);
      start = wr_en && wr_addr == 4'd0 && wr_data[31] && !ctl[31];
      run   = ctl[31] && ctl[18];
      last  = ms_tick && (m_ms == m_r[1][15:0]);
      inc   = evt_pulse ? m_r[7] : 32'h0;
      sum   = {1'b0, m_acc} + {1'b0, inc};
      n_acc = m_acc; n_ms = m_ms; n_cq = 1'b0; n_sq = m_sq;
      if (start) begin
        n_acc = '0; n_ms = '0;
      end else if (run) begin
        if (last) begin
          n_cq = 1'b1; n_sq = sum[32] ? 32'hFFFF_FFFF : sum[31:0];
          n_acc = '0; n_ms = '0;
        end else begin
          n_acc = sum[32] ? 32'hFFFF_FFFF : sum[31:0];
          if (ms_tick) n_ms = m_ms + 16'd1;
        end
      end
      d   = (longint'(m_sq) - longint'(m_r[8])) >>> (int'(ctl[12:10]) + 1);
      nav = 32'(longint'(m_r[8]) + d);
      n_avg = start ? m_r[6] : (m_cq ? nav : m_r[8]);
      setb = '0;
      if (m_cq && !start) begin
        if (ctl[21] && nav > m_r[4]) setb[1] = 1'b1;
        if (ctl[20] && nav < m_r[5]) setb[0] = 1'b1;
      end
      n_ca = m_ca;
      hit  = m_sq > m_r[2];
      if (start || !ctl[30]) n_ca = 0;
      else if (m_cq) begin
        if (hit && m_ca == int'(ctl[28:26])) begin setb[3] = 1'b1; n_ca = 0; end
        else if (hit) n_ca = m_ca + 1;
        else n_ca = 0;
      end
      n_cb = m_cb;
      hit  = m_sq < m_r[3];
      if (start || !ctl[29]) n_cb = 0;
      else if (m_cq) begin
        if (hit && m_cb == int'(ctl[25:23])) begin setb[2] = 1'b1; n_cb = 0; end
        else if (hit) n_cb = m_cb + 1;
        else n_cb = 0;
      end
      st = m_r[9][31:28];
      if (wr_en && wr_addr == 4'd9) st = st & ~wr_data[31:28];
      st = st | setb;
      if (wr_en && wr_addr <= 4'd7) begin
        if (wr_addr == 4'd0)      m_r[0] = wr_data & CTRL_MASK;
        else if (wr_addr == 4'd1) m_r[1] = {16'h0, wr_data[15:0]};
        else                      m_r[wr_addr] = wr_data;
      end
      m_r[8] = n_avg; m_r[9] = {st, 28'h0};
      m_acc = n_acc; m_ms = n_ms; m_cq = n_cq; m_sq = n_sq;
      m_ca = n_ca; m_cb = n_cb;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      check(tag_of(m_ra), rd_data, m_rd);
      check("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic evt_once();
    @(negedge clk); evt_pulse = 1'b1;
    @(negedge clk); evt_pulse = 1'b0;
  endtask

  task automatic tick_once(input logic with_evt);
    @(negedge clk); ms_tick = 1'b1; evt_pulse = with_evt;
    @(negedge clk); ms_tick = 1'b0; evt_pulse = 1'b0;
  endtask

  // n events, then two ticks (period register = 1)
  task automatic run_period(input int n);
    for (int i = 0; i < n; i++) evt_once();
    tick_once(1'b0);
    tick_once(1'b0);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] CFG_A = 32'hE434_0400;
  logic [31:0] v;
  logic [31:0] lf;
  logic [31:0] rcfg;

  initial begin : watchdog
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: every register reads zero after reset
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      check("R1 reset value", v, 32'h0);
    end
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    wr(4'd1, 32'd1);
    wr(4'd2, 32'd50);
    wr(4'd3, 32'd20);
    wr(4'd4, 32'd2000);
    wr(4'd5, 32'd5);
    wr(4'd6, 32'd1000);
    wr(4'd7, 32'd10);
    rd(4'd2, v); check("R2 upper mark readback", v, 32'd50);
    rd(4'd7, v); check("R2 weight readback", v, 32'd10);
    rd(4'd1, v); check("R2 period readback", v, 32'd1);
    wr(4'd0, CFG_A | 32'h0000_0003);
    rd(4'd0, v); check("R2 control keeps only defined fields", v, CFG_A);
    rd(4'd8, v); check("R4 average seeded", v, 32'd1000);

    run_period(3);
    rd(4'd8, v); check("R4 avg after sample 30", v, 32'd757);
    run_period(6);
    rd(4'd8, v); check("R4 avg after sample 60", v, 32'd582);
    rd(4'd9, v); check("R5 one breach is not enough", v, 32'h0);
    run_period(6);
    rd(4'd9, v); check("R5 two breaches set bit 31", v, 32'h8000_0000);
    step(2);
    check("R9 irq from upper streak", {31'h0, irq}, 32'h1);
    wr(4'd9, 32'h8000_0000);
    rd(4'd9, v); check("R8 clear bit 31", v, 32'h0);
    step(1);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    run_period(6);
    run_period(3);
    run_period(6);
    rd(4'd9, v); check("R5 miss breaks the streak", v, 32'h0);
    run_period(1);
    rd(4'd9, v); check("R6 lower streak sets bit 30", v, 32'h4000_0000);
    wr(4'd9, 32'hFFFF_FFFF);

    // reseed and trip both lower streak and average-above
    wr(4'd4, 32'd100);
    wr(4'd0, CFG_A & ~32'h8000_0000);
    wr(4'd0, CFG_A);
    run_period(1);
    rd(4'd9, v); check("R7 avg-above and lower streak", v, 32'h6000_0000);
    rd(4'd8, v); check("R4 reseed then sample 10", v, 32'd752);
    wr(4'd9, 32'h4000_0000);
    rd(4'd9, v); check("R8 partial clear keeps bit 29", v, 32'h2000_0000);
    check("R9 irq from avg-above", {31'h0, irq}, 32'h1);
    wr(4'd0, CFG_A & ~32'h0020_0000);
    step(2);
    check("R9 enable masks latched bit", {31'h0, irq}, 32'h0);

    // R10: master enable cleared
    wr(4'd0, CFG_A & ~32'h8020_0000);
    run_period(6);
    run_period(1);
    rd(4'd8, v); check("R10 average held while stopped", v, 32'd752);
    rd(4'd2, v); check("R10 upper mark intact", v, 32'd50);
    rd(4'd9, v); check("R10 status untouched", v, 32'h2000_0000);

    // R12: streak directions disabled
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd0, 32'h8034_0400);
    run_period(1);
    run_period(6);
    rd(4'd9, v); check("R12 no streak bits when disabled", v, 32'h2000_0000);

    // R3: event on the closing tick counts
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd6, 32'd0);
    wr(4'd0, 32'h8004_0000);
    evt_once();
    tick_once(1'b0);
    tick_once(1'b1);
    step(1);
    rd(4'd8, v); check("R3 closing-cycle event counted", v, 32'd10);

    // R11: saturation
    wr(4'd0, 32'h0);
    wr(4'd7, 32'hFFFF_FFF0);
    wr(4'd0, 32'h8004_0000);
    run_period(2);
    rd(4'd8, v); check("R11 accumulator saturates", v, 32'h7FFF_FFFF);

    // pseudo-random traffic compared against the model
    wr(4'd0, 32'h0);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd7, 32'd3);
    wr(4'd1, 32'd2);
    wr(4'd2, 32'd15);
    wr(4'd3, 32'd12);
    wr(4'd4, 32'd20);
    wr(4'd5, 32'd14);
    wr(4'd6, 32'd16);
    rcfg = 32'hE534_0800;
    wr(4'd0, rcfg);
    lf = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      evt_pulse = lf[0] & lf[3];
      ms_tick   = (lf[7:5] == 3'd0);
      rd_addr   = 4'(i % 10);
      wr_en     = 1'b0;
      if (lf[15:10] == 6'd0) begin
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = {lf[31:28], 28'h0};
      end else if (lf[22:16] == 7'd0) begin
        rcfg = rcfg ^ 32'h0004_0000;
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = rcfg;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; evt_pulse = 1'b0; ms_tick = 1'b0;
    step(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule